// File: doc/BRIEF.md
# Bridge configuration register file

This block holds the configuration space of a PCI-to-PCI root port bridge as a synthesizable register file. It stores the 64-byte Type 1 header. When the PCI Express capability is enabled, it also stores a 60-byte capability structure that follows the header at byte 0x40. A single access port carries the following fields:
- a dword address
- a byte offset
- an access size of 1, 2 or 4 bytes
- write data

Every access gets a response one clock later. The response carries the read data and a bad-register flag.

Each dword has three masks: read-only, read-write and write-1-to-clear. A bit in none of the three masks is reserved.
- A read returns the stored dword ANDed with the union of the three masks. For a 1-byte or 2-byte read, the result is then shifted down and trimmed to the access width.
- A write is a read-modify-write restricted to the byte lanes the access covers:
  - Read-write bits inside the lanes take the new data.
  - Write-1-to-clear bits inside the lanes clear where the data is 1.
  - Every other bit keeps its value.

A sideband port lets status logic set write-1-to-clear bits of one dword per clock.

Two parameters shape the attributes:
- `PCIE_EN` enables the capability structure. It also turns the PCI-only header bits into reserved bits.
- `NO_PREF` makes the whole prefetchable base/limit dword read-only.

Top module: `bridge_cfg_regfile`

## Requirements
- R1: After reset, the header reads as follows.
  - Dword 0: `ID_WORD`.
  - Dword 2: `{24'h060400, REV_ID}`.
  - Dword 3: `32'h0001_0010`, which is cache line size 0x10 and header type 0x01.
  - Dword 1: status bit 20 set. This is capability-list bit 4 of the status half.
  - With `PCIE_EN`=1, the byte at 0x34 reads 0x40 and capability dword 16 reads `32'h0040_0010`. That is capability ID 0x10 with port type 4 in bits 23:20.
- R2: Every access with `req_valid` high gives `rsp_valid` high on the next clock and at no other time. A write response carries zero data. A write is seen by a read issued in the very next cycle.
- R3: Writes never change read-only bits, and reserved bits always read as zero. Examples:
  - Writing all ones to dword 0 leaves `ID_WORD`.
  - Writing all ones to dword 6 (bus numbers, bits 23:0 read-write) reads back `32'h00FF_FFFF`.
  - Writing all ones to capability dword 18 reads back `32'h0000_7FFF`.
- R4: A read of size 1 or 2 returns the dword shifted right by 8 times `req_off`, masked to 8 or 16 bits. A read of size 4 ignores `req_off`.
- R5: A write of size 1 or 2 touches only bytes `req_off` upward within the width, taking the data from the low bytes of `req_wdata`. A size-4 write covers all four bytes and ignores `req_off`.
- R6: Write-1-to-clear bits behave as follows.
  - Inside the written lanes, a data 1 clears the bit and a data 0 keeps it.
  - Outside the lanes the bit is kept.
- R7: `hw_set_valid` sets the `hw_set_bits` of dword `hw_set_addr`, but only on write-1-to-clear bits. If a set and a write-1-to-clear hit the same bit in the same cycle, the set wins.
- R8: Addresses at or above the end of the implemented space are out of range:
  - the end is dword 31 with `PCIE_EN`=1 and dword 16 otherwise;
  - an out-of-range read returns zero with `rsp_bad` low, whatever the size;
  - an out-of-range write changes nothing, including the dword its low address bits alias.
- R9: In range, a size other than 1, 2 or 4 gives `rsp_bad` high and zero data. Such a write changes nothing.
- R10: The memory base/limit dword 8 has bits 31:20 and 15:4 read-write, so all ones reads `32'hFFF0_FFF0`. Link control/status dword 20 has read-write bits 15:14, 11:9, 7:3 and 1:0. Its read-only status bits reset to zero, so all ones reads `32'h0000_CEFB`.
- R11: With `NO_PREF`=0, prefetchable dword 9 behaves like dword 8, so all ones reads `32'hFFF0_FFF0`. With `NO_PREF`=1 it is fully read-only and keeps its reset value 0.
- R12: Some header bits depend on `PCIE_EN`.
  - Bridge-control dword 15 written with all ones reads `32'h0B6F_00FF` with `PCIE_EN`=0 and `32'h004F_00FF` with `PCIE_EN`=1.
  - With `PCIE_EN`=0, the capability pointer reads 0 and dword 16 is out of range.
  - With `PCIE_EN`=0, dword 3 keeps `32'h0001_0010`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Dword address |
| req_off | input | 2 | Byte offset inside the dword |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, low-aligned |
| hw_set_valid | input | 1 | Sideband status-set strobe |
| hw_set_addr | input | ADDR_W | Dword that the sideband set targets |
| hw_set_bits | input | 32 | Bits to set (write-1-to-clear bits only) |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_bad | output | 1 | Unsupported access size |
| rsp_rdata | output | 32 | Read data, low-aligned |

## Verification
Writes of all ones are sent to dwords of each attribute mix: fully read-only, fully read-write, split bus-number, base/limit, link control/status and bridge control. The read-backs tell the read-write bits apart from the read-only and reserved bits. Sub-dword writes and reads at odd offsets, including a 2-byte access at offset 3, separate lane masking from shifting. A 4-byte write at a non-zero offset confirms that the offset is ignored. Sideband sets and clears on device status show the following:
- sets land only on write-1-to-clear bits;
- a clear outside the written lanes has no effect;
- a set beats a clear in the same cycle.

A second instance in plain PCI mode with the prefetchable dword read-only shows the mode-dependent masks and the shorter address range.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    localparam int unsigned HDR_DWORDS = 16;
    localparam int unsigned CAP_DWORDS = 15;

    typedef struct packed {
        logic [31:0] ro;
        logic [31:0] rw;
        logic [31:0] w1c;
    } attr_t;

    // Bit attributes per dword index; a bit in no mask is reserved.
    function automatic attr_t attr_lookup(int unsigned idx, bit pcie, bit nopref);
        attr_t a;
        a = '0;
        case (idx)
            0, 2, 4, 5, 14: a.ro = '1;
            1: begin
                a.rw  = 32'h0000_0145;
                a.w1c = 32'hF900_0000;
                a.ro  = pcie ? 32'h0010_0000 : 32'h06B0_02B8;
            end
            3:  a.ro = pcie ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
            6: begin
                a.rw = 32'h00FF_FFFF;
                a.ro = pcie ? 32'h0000_0000 : 32'hFF00_0000;
            end
            7: begin
                a.rw  = 32'h0000_F0F0;
                a.ro  = 32'h0000_0F0F | (pcie ? 32'h0 : 32'h06A0_0000);
                a.w1c = 32'hF900_0000;
            end
            8: begin
                a.rw = 32'hFFF0_FFF0;
                a.ro = 32'h000F_000F;
            end
            9: begin
                if (nopref) begin
                    a.ro = '1;
                end else begin
                    a.rw = 32'hFFF0_FFF0;
                    a.ro = 32'h000F_000F;
                end
            end
            10, 11, 12: a.rw = '1;
            13: a.ro = 32'h0000_00FF;
            15: begin
                if (pcie) begin
                    a.rw = 32'h004F_00FF;
                    a.ro = 32'h0000_FF00;
                end else begin
                    a.rw  = 32'h0B6F_00FF;
                    a.ro  = 32'h0080_FF00;
                    a.w1c = 32'h0400_0000;
                end
            end
            16: a.ro = 32'h7FFF_FFFF;
            17: a.ro = 32'h0000_803F;
            18: begin
                a.rw  = 32'h0000_7FFF;
                a.w1c = 32'h000F_0000;
                a.ro  = 32'h0030_0000;
            end
            19: a.ro = 32'hFF7B_FFFF;
            20: begin
                a.rw  = 32'h0000_CEFB;
                a.ro  = 32'h3FFF_0000;
                a.w1c = 32'hC000_0000;
            end
            21: a.ro = '1;
            22: begin
                a.rw  = 32'h0000_7FFF;
                a.w1c = 32'h011F_0000;
                a.ro  = 32'h00E0_0000;
            end
            23: begin
                a.rw = 32'h0000_001F;
                a.ro = 32'h0001_0000;
            end
            24: begin
                a.ro  = 32'h0002_FFFF;
                a.w1c = 32'h0001_0000;
            end
            25: a.ro = 32'h80FF_FFFF;
            26: a.rw = 32'h0000_F7FF;
            27: a.ro = 32'h81FF_FFFE;
            28: begin
                a.rw  = 32'h0000_FFFF;
                a.w1c = 32'h8020_0000;
                a.ro  = 32'h73DF_0000;
            end
            default: a = '0;
        endcase
        return a;
    endfunction

    function automatic logic [31:0] reset_value(int unsigned idx, bit pcie,
                                                logic [31:0] id_word, logic [7:0] rev);
        case (idx)
            0:       return id_word;
            1:       return 32'h0010_0000;
            2:       return {24'h060400, rev};
            3:       return 32'h0001_0010;
            13:      return pcie ? 32'h0000_0040 : 32'h0;
            16:      return 32'h0040_0010;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/cfgrf_lane.sv
module cfgrf_lane (
    input  logic [2:0]  size,
    input  logic [1:0]  off,
    output logic [31:0] lane_mask,
    output logic [4:0]  shamt,
    output logic        size_ok
);
    always_comb begin
        shamt   = {off, 3'b000};
        size_ok = 1'b1;
        case (size)
            3'd1:    lane_mask = 32'h0000_00FF << shamt;
            3'd2:    lane_mask = 32'h0000_FFFF << shamt;
            3'd4: begin
                lane_mask = 32'hFFFF_FFFF;
                shamt     = 5'd0;
            end
            default: begin
                lane_mask = 32'h0;
                shamt     = 5'd0;
                size_ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfgrf_attr.sv
module cfgrf_attr
    import cfgrf_pkg::*;
#(
    parameter bit PCIE_EN = 1'b1,
    parameter bit NO_PREF = 1'b0,
    parameter int ADDR_W  = 6
) (
    input  logic [ADDR_W-1:0] idx,
    output attr_t             attr,
    output logic              in_range
);
    localparam int NDW = PCIE_EN ? (HDR_DWORDS + CAP_DWORDS) : HDR_DWORDS;
    localparam int IW  = $clog2(NDW);

    attr_t tbl [NDW];

    for (genvar g = 0; g < NDW; g++) begin : g_tbl
        assign tbl[g] = attr_lookup(g, PCIE_EN, NO_PREF);
    end

    always_comb begin
        in_range = (int'(idx) < NDW);
        attr     = in_range ? tbl[idx[IW-1:0]] : '0;
    end
endmodule

// File: rtl/cfgrf_rd_align.sv
module cfgrf_rd_align (
    input  logic [31:0] dword,
    input  logic [4:0]  shamt,
    input  logic [2:0]  size,
    output logic [31:0] rdata
);
    always_comb begin
        case (size)
            3'd1:    rdata = (dword >> shamt) & 32'h0000_00FF;
            3'd2:    rdata = (dword >> shamt) & 32'h0000_FFFF;
            default: rdata = dword;
        endcase
    end
endmodule

// File: rtl/bridge_cfg_regfile.sv
module bridge_cfg_regfile
    import cfgrf_pkg::*;
#(
    parameter bit          PCIE_EN = 1'b1,
    parameter bit          NO_PREF = 1'b0,
    parameter int          ADDR_W  = 6,
    parameter logic [31:0] ID_WORD = 32'h7A51_1B2C,
    parameter logic [7:0]  REV_ID  = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_off,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              hw_set_valid,
    input  logic [ADDR_W-1:0] hw_set_addr,
    input  logic [31:0]       hw_set_bits,
    output logic              rsp_valid,
    output logic              rsp_bad,
    output logic [31:0]       rsp_rdata
);
    localparam int NDW = PCIE_EN ? (HDR_DWORDS + CAP_DWORDS) : HDR_DWORDS;
    localparam int IW  = $clog2(NDW);

    typedef struct packed {
        logic [NDW-1:0][31:0] regs;
        logic                 rsp_valid;
        logic                 rsp_bad;
        logic [31:0]          rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NDW-1:0][31:0] rst_regs;

    for (genvar g = 0; g < NDW; g++) begin : g_rst
        localparam attr_t A = attr_lookup(g, PCIE_EN, NO_PREF);
        assign rst_regs[g] = reset_value(g, PCIE_EN, ID_WORD, REV_ID) & (A.ro | A.rw | A.w1c);
    end

    attr_t       rq_attr, hw_attr;
    logic        rq_in_rng, hw_in_rng;
    logic [31:0] lane_m;
    logic [4:0]  shamt;
    logic        size_ok;
    logic [31:0] old_dw, rd_aligned;

    cfgrf_attr #(.PCIE_EN(PCIE_EN), .NO_PREF(NO_PREF), .ADDR_W(ADDR_W)) u_rq_attr (
        .idx      (req_addr),
        .attr     (rq_attr),
        .in_range (rq_in_rng)
    );

    cfgrf_attr #(.PCIE_EN(PCIE_EN), .NO_PREF(NO_PREF), .ADDR_W(ADDR_W)) u_hw_attr (
        .idx      (hw_set_addr),
        .attr     (hw_attr),
        .in_range (hw_in_rng)
    );

    cfgrf_lane u_lane (
        .size      (req_size),
        .off       (req_off),
        .lane_mask (lane_m),
        .shamt     (shamt),
        .size_ok   (size_ok)
    );

    cfgrf_rd_align u_align (
        .dword (old_dw & (rq_attr.ro | rq_attr.rw | rq_attr.w1c)),
        .shamt (shamt),
        .size  (req_size),
        .rdata (rd_aligned)
    );

    assign old_dw = rq_in_rng ? st_q.regs[req_addr[IW-1:0]] : 32'h0;

    always_comb begin
        logic [31:0] wd_sh;
        logic [31:0] nxt;

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_bad   = 1'b0;
        st_d.rdata     = 32'h0;

        wd_sh = req_wdata << shamt;
        // keep non-written bits, load read-write lanes, then clear written ones
        nxt   = (old_dw & ~(rq_attr.rw & lane_m)) | (wd_sh & rq_attr.rw & lane_m);
        nxt   = nxt & ~(wd_sh & rq_attr.w1c & lane_m);

        if (req_valid && rq_in_rng) begin
            if (!size_ok) begin
                st_d.rsp_bad = 1'b1;
            end else if (req_write) begin
                st_d.regs[req_addr[IW-1:0]] = nxt;
            end else begin
                st_d.rdata = rd_aligned;
            end
        end

        // sideband set is applied last so it wins against a same-cycle clear
        if (hw_set_valid && hw_in_rng) begin
            st_d.regs[hw_set_addr[IW-1:0]] = st_d.regs[hw_set_addr[IW-1:0]]
                | (hw_set_bits & hw_attr.w1c & ~(hw_attr.ro | hw_attr.rw));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs      <= rst_regs;
            st_q.rsp_valid <= 1'b0;
            st_q.rsp_bad   <= 1'b0;
            st_q.rdata     <= 32'h0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_bad   = st_q.rsp_bad;
    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/bridge_cfg_regfile_chk.sv
module bridge_cfg_regfile_chk #(
    parameter bit PCIE_EN = 1'b1,
    parameter int ADDR_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_bad,
    input logic [31:0]       rsp_rdata
);
    localparam int LIMIT = PCIE_EN ? 31 : 16;

    logic in_rng, legal_size;
    assign in_rng     = int'(req_addr) < LIMIT;
    assign legal_size = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));

    a_r8_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_rng) |=> (!rsp_bad && rsp_rdata == 32'h0));

    a_r9_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_rng && !legal_size) |=> (rsp_bad && rsp_rdata == 32'h0));

    a_r4_byte_read_width: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 3'd1) |=> (rsp_rdata[31:8] == 24'h0));

    a_r4_half_read_width: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 3'd2) |=> (rsp_rdata[31:16] == 16'h0));

endmodule

bind bridge_cfg_regfile bridge_cfg_regfile_chk #(.PCIE_EN(PCIE_EN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_bad   (rsp_bad),
    .rsp_rdata (rsp_rdata)
);

// File: tb/bridge_cfg_regfile_bench.sv
module bridge_cfg_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_a = 1'b0, req_valid_b = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [1:0]  req_off = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        hw_set_valid = 1'b0;
    logic [5:0]  hw_set_addr = '0;
    logic [31:0] hw_set_bits = '0;
    logic        rsp_valid_a, rsp_bad_a, rsp_valid_b, rsp_bad_b;
    logic [31:0] rsp_rdata_a, rsp_rdata_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bridge_cfg_regfile u_bridge_cfg_regfile (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid_a), .req_write(req_write), .req_addr(req_addr),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .hw_set_valid(hw_set_valid), .hw_set_addr(hw_set_addr), .hw_set_bits(hw_set_bits),
        .rsp_valid(rsp_valid_a), .rsp_bad(rsp_bad_a), .rsp_rdata(rsp_rdata_a)
    );

    bridge_cfg_regfile #(.PCIE_EN(1'b0), .NO_PREF(1'b1)) u_bridge_cfg_regfile_pci (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid_b), .req_write(req_write), .req_addr(req_addr),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .hw_set_valid(1'b0), .hw_set_addr(6'd0), .hw_set_bits(32'h0),
        .rsp_valid(rsp_valid_b), .rsp_bad(rsp_bad_b), .rsp_rdata(rsp_rdata_b)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [1:0]  off;
        logic [2:0]  sz;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        bad;
    } vec_t;

    localparam int NVEC = 33;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 6'd0,  2'd0, 3'd4, 32'h0,        32'h7A51_1B2C, 1'b0},  // R1
        '{1'b0, 6'd2,  2'd0, 3'd4, 32'h0,        32'h0604_0003, 1'b0},  // R1
        '{1'b0, 6'd3,  2'd0, 3'd4, 32'h0,        32'h0001_0010, 1'b0},  // R1
        '{1'b0, 6'd1,  2'd0, 3'd4, 32'h0,        32'h0010_0000, 1'b0},  // R1
        '{1'b0, 6'd13, 2'd0, 3'd1, 32'h0,        32'h0000_0040, 1'b0},  // R1
        '{1'b0, 6'd16, 2'd0, 3'd4, 32'h0,        32'h0040_0010, 1'b0},  // R1
        '{1'b1, 6'd0,  2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R3
        '{1'b0, 6'd0,  2'd0, 3'd4, 32'h0,        32'h7A51_1B2C, 1'b0},  // R3
        '{1'b1, 6'd6,  2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R3
        '{1'b0, 6'd6,  2'd0, 3'd4, 32'h0,        32'h00FF_FFFF, 1'b0},  // R3
        '{1'b1, 6'd6,  2'd1, 3'd1, 32'h0000_005A, 32'h0,        1'b0},  // R5
        '{1'b0, 6'd6,  2'd0, 3'd4, 32'h0,        32'h00FF_5AFF, 1'b0},  // R5
        '{1'b0, 6'd6,  2'd1, 3'd2, 32'h0,        32'h0000_FF5A, 1'b0},  // R4
        '{1'b0, 6'd6,  2'd2, 3'd1, 32'h0,        32'h0000_00FF, 1'b0},  // R4
        '{1'b0, 6'd6,  2'd3, 3'd2, 32'h0,        32'h0000_0000, 1'b0},  // R4
        '{1'b1, 6'd8,  2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R10
        '{1'b0, 6'd8,  2'd0, 3'd4, 32'h0,        32'hFFF0_FFF0, 1'b0},  // R10
        '{1'b1, 6'd20, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R10
        '{1'b0, 6'd20, 2'd0, 3'd4, 32'h0,        32'h0000_CEFB, 1'b0},  // R10
        '{1'b0, 6'd0,  2'd0, 3'd3, 32'h0,        32'h0,         1'b1},  // R9
        '{1'b1, 6'd10, 2'd0, 3'd3, 32'h0000_1234, 32'h0,        1'b1},  // R9
        '{1'b0, 6'd10, 2'd0, 3'd4, 32'h0,        32'h0,         1'b0},  // R9
        '{1'b1, 6'd10, 2'd2, 3'd2, 32'h0000_BEEF, 32'h0,        1'b0},  // R5
        '{1'b0, 6'd10, 2'd0, 3'd4, 32'h0,        32'hBEEF_0000, 1'b0},  // R5
        '{1'b1, 6'd10, 2'd2, 3'd4, 32'h1122_3344, 32'h0,        1'b0},  // R5
        '{1'b0, 6'd10, 2'd0, 3'd4, 32'h0,        32'h1122_3344, 1'b0},  // R5
        '{1'b0, 6'd31, 2'd0, 3'd4, 32'h0,        32'h0,         1'b0},  // R8
        '{1'b0, 6'd63, 2'd1, 3'd1, 32'h0,        32'h0,         1'b0},  // R8
        '{1'b0, 6'd40, 2'd0, 3'd3, 32'h0,        32'h0,         1'b0},  // R8
        '{1'b1, 6'd42, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R8
        '{1'b0, 6'd10, 2'd0, 3'd4, 32'h0,        32'h1122_3344, 1'b0},  // R8
        '{1'b1, 6'd18, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0,        1'b0},  // R3
        '{1'b0, 6'd18, 2'd0, 3'd4, 32'h0,        32'h0000_7FFF, 1'b0}   // R3
    };

    // Starts at a falling edge; the response is registered at the next rising edge.
    task automatic access(input bit sel_b, input bit wr, input logic [5:0] a,
                          input logic [1:0] o, input logic [2:0] s, input logic [31:0] wd,
                          input logic [31:0] exp, input bit exp_bad, input string tag);
        logic        v, b;
        logic [31:0] d;
        req_write = wr;
        req_addr  = a;
        req_off   = o;
        req_size  = s;
        req_wdata = wd;
        if (sel_b) req_valid_b = 1'b1;
        else       req_valid_a = 1'b1;
        @(negedge clk);
        v = sel_b ? rsp_valid_b : rsp_valid_a;
        b = sel_b ? rsp_bad_b   : rsp_bad_a;
        d = sel_b ? rsp_rdata_b : rsp_rdata_a;
        req_valid_a = 1'b0;
        req_valid_b = 1'b0;
        n_checks++;
        if (v !== 1'b1 || b !== exp_bad || d !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d: valid=%b bad=%b data=%h, expected valid=1 bad=%b data=%h",
                     tag, a, v, b, d, exp_bad, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: no response while held in reset
        n_checks++;
        if (rsp_valid_a !== 1'b0 || rsp_valid_b !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 reset: rsp_valid=%b/%b, expected 0/0", rsp_valid_a, rsp_valid_b);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (rsp_valid_a !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle: rsp_valid=%b, expected 0", rsp_valid_a);
        end

        for (int i = 0; i < NVEC; i++) begin
            access(1'b0, VEC[i].wr, VEC[i].addr, VEC[i].off, VEC[i].sz, VEC[i].wd,
                   VEC[i].exp, VEC[i].bad, $sformatf("vector %0d", i));
        end

        // R7: sideband set lands only on write-1-to-clear bits
        hw_set_addr = 6'd18; hw_set_bits = 32'hFFFF_FFFF; hw_set_valid = 1'b1;
        @(negedge clk);
        hw_set_valid = 1'b0;
        access(1'b0, 1'b0, 6'd18, 2'd0, 3'd4, 32'h0, 32'h000F_7FFF, 1'b0, "R7 set w1c only");
        // R6: written ones clear inside the lane, zeros keep
        access(1'b0, 1'b1, 6'd18, 2'd2, 3'd1, 32'h05, 32'h0, 1'b0, "R6 clear write");
        access(1'b0, 1'b0, 6'd18, 2'd0, 3'd4, 32'h0, 32'h000A_7FFF, 1'b0, "R6 clear result");
        // R6: status bits outside the lane keep their value
        access(1'b0, 1'b1, 6'd18, 2'd0, 3'd1, 32'h00, 32'h0, 1'b0, "R6 out-of-lane write");
        access(1'b0, 1'b0, 6'd18, 2'd0, 3'd4, 32'h0, 32'h000A_7F00, 1'b0, "R6 out-of-lane result");
        // R7: set wins over same-cycle clear
        hw_set_addr = 6'd18; hw_set_bits = 32'h0008_0000; hw_set_valid = 1'b1;
        access(1'b0, 1'b1, 6'd18, 2'd0, 3'd4, 32'h000F_7F00, 32'h0, 1'b0, "R7 collide write");
        hw_set_valid = 1'b0;
        access(1'b0, 1'b0, 6'd18, 2'd0, 3'd4, 32'h0, 32'h0008_7F00, 1'b0, "R7 set wins");
        // R7/R6: header status error bit
        hw_set_addr = 6'd1; hw_set_bits = 32'h8000_0000; hw_set_valid = 1'b1;
        @(negedge clk);
        hw_set_valid = 1'b0;
        access(1'b0, 1'b0, 6'd1, 2'd0, 3'd4, 32'h0, 32'h8010_0000, 1'b0, "R7 status set");
        access(1'b0, 1'b1, 6'd1, 2'd2, 3'd2, 32'h8000, 32'h0, 1'b0, "R6 status clear write");
        access(1'b0, 1'b0, 6'd1, 2'd0, 3'd4, 32'h0, 32'h0010_0000, 1'b0, "R6 status cleared");

        // R11: prefetchable dword read-write on the default instance
        access(1'b0, 1'b1, 6'd9, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, "R11 pref write");
        access(1'b0, 1'b0, 6'd9, 2'd0, 3'd4, 32'h0, 32'hFFF0_FFF0, 1'b0, "R11 pref rw");
        // R12: bridge control in express mode
        access(1'b0, 1'b1, 6'd15, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, "R12 bctl write");
        access(1'b0, 1'b0, 6'd15, 2'd0, 3'd4, 32'h0, 32'h004F_00FF, 1'b0, "R12 bctl pcie");

        // PCI-mode instance, prefetchable read-only
        access(1'b1, 1'b0, 6'd13, 2'd0, 3'd4, 32'h0, 32'h0, 1'b0, "R12 cap ptr zero");
        access(1'b1, 1'b0, 6'd16, 2'd0, 3'd4, 32'h0, 32'h0, 1'b0, "R12 range end");
        access(1'b1, 1'b0, 6'd3, 2'd0, 3'd4, 32'h0, 32'h0001_0010, 1'b0, "R12 dword3");
        access(1'b1, 1'b0, 6'd1, 2'd0, 3'd4, 32'h0, 32'h0010_0000, 1'b0, "R1 pci status");
        access(1'b1, 1'b1, 6'd9, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, "R11 ro write");
        access(1'b1, 1'b0, 6'd9, 2'd0, 3'd4, 32'h0, 32'h0, 1'b0, "R11 pref read-only");
        access(1'b1, 1'b1, 6'd6, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, "R12 bus write");
        access(1'b1, 1'b0, 6'd6, 2'd0, 3'd4, 32'h0, 32'h00FF_FFFF, 1'b0, "R12 latency ro");
        access(1'b1, 1'b1, 6'd15, 2'd0, 3'd4, 32'hFFFF_FFFF, 32'h0, 1'b0, "R12 bctl write pci");
        access(1'b1, 1'b0, 6'd15, 2'd0, 3'd4, 32'h0, 32'h0B6F_00FF, 1'b0, "R12 bctl pci");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule